// File: doc/BRIEF.md
# Pipelined Auxiliary Address Register Unit

This unit keeps the two 16-bit address registers of a small in-order control processor. The processor issues one instruction per cycle. Each instruction is seen by the unit in its second decode stage (D2), then moves through R1 and R2 and reaches execute (EXE) three cycles later. Indirect addressing reads the chosen register in D2 and may post-increment it there by a signed 16-bit step. An instruction that loads a register from memory is recognised by its upper opcode word in D2. A token for it runs down an internal three-stage pipe, and the memory word is written into the register only when the token reaches EXE.

Because the two kinds of write land at different stages, the two instructions that follow a load still read the old value. The third follows the load by exactly the pipe depth, so it is in D2 in the same cycle that the load is in EXE. If that third instruction post-increments the same register, the increment is kept, the loaded word is thrown away, and a one-cycle flag reports the dropped load. From the fourth instruction on, the loaded value is visible. The load never touches any status flag, and the unit has no flag inputs or outputs.

Stream rules: the indirect-access request and the memory word are qualified by `ind_valid` and by the load token. There is no ready signal, because the unit takes a request in every cycle and never applies back-pressure. The caller must present one instruction word per cycle and send a non-load word in idle slots.

Top module: `aux_addr_unit`

## Requirements
- R1: A synchronous active-high `rst` clears both registers to 0 and `ld_drop` to 0, and cancels any load already in flight, so no load issued before reset is ever written.
- R2: An upper opcode word whose bits [15:4] equal 12'h760 is a load of register 0. Bits [15:4] equal to 12'h764 make it a load of register 1. Bits [3:0] are ignored. Any other word is not a load and never changes a register.
- R3: A load seen on `opc_hi` in cycle t writes the `mem_rdata` value present in cycle t+3 into its target, and that value is visible on the register outputs and on `addr_out` from cycle t+4.
- R4: `addr_out` shows, in the same cycle, the current value of the register selected by `ind_sel`. The first three instructions after a load therefore read the pre-load value.
- R5: When `ind_valid` and `ind_inc` are both high, the selected register becomes its value plus `ind_step` modulo 2^16. The new value is visible in the next cycle.
- R6: If a post-increment and a load in EXE target the same register in the same cycle, the register takes the incremented value, the loaded word is discarded, and `ld_drop` is high for exactly the following cycle.
- R7: A post-increment of one register and a load of the other register in the same cycle both take effect.
- R8: `ld_drop` is low in every cycle that does not follow a collision.
- R9: A register that is neither post-incremented nor loaded keeps its value, including when it is only read through `addr_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opc_hi | input | 16 | Upper opcode word of the instruction now in D2 |
| mem_rdata | input | 16 | Memory word for the load now in EXE |
| ind_valid | input | 1 | The instruction in D2 uses indirect addressing |
| ind_sel | input | 1 | Register used by the indirect access |
| ind_inc | input | 1 | Post-increment the selected register |
| ind_step | input | 16 | Signed post-increment step |
| addr_out | output | 16 | Current value of the selected register |
| ar0 | output | 16 | Register 0 |
| ar1 | output | 16 | Register 1 |
| ld_drop | output | 1 | Pulses for one cycle after a load loses a collision |

## Verification
On every cycle, the assertions check the per-register update rules: increment applied, load committed when there is no collision, value held when neither write is present, clear on reset. They also check that a drop pulse always has a collision behind it, that load tokens move one stage per cycle, and that the opcode decoder only recognises the load form. Only the bench's scenarios can show the end-to-end instruction timing. That covers the old value read by the first three instructions after a load, the new value from the fourth, the exact cycle in which the memory word is sampled, rejection of look-alike opcodes, wrap-around of negative steps, and cancellation of a load that is in flight when reset arrives.

// File: rtl/aux_pkg.sv
package aux_pkg;
  localparam int unsigned AW      = 16;
  localparam int unsigned NREG    = 2;
  localparam int unsigned SW      = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int unsigned LD_LAT  = 3;   // D2 -> R1 -> R2 -> EXE
  localparam int unsigned OPC_HIW = 12;  // opcode bits compared

  // load forms, bits [15:4] of the upper opcode word
  localparam logic [OPC_HIW-1:0] LD_FORM0 = 12'h760;
  localparam logic [OPC_HIW-1:0] LD_FORM1 = 12'h764;

  typedef struct packed {
    logic          vld;
    logic [SW-1:0] sel;
  } ld_tok_t;
endpackage

// File: rtl/aux_opc_dec.sv
module aux_opc_dec
  import aux_pkg::*;
(
  input  logic [OPC_HIW-1:0] opc_bits,
  output ld_tok_t            tok
);
  logic is_form0;
  logic is_form1;

  always_comb begin
    is_form0 = (opc_bits == LD_FORM0);
    is_form1 = (opc_bits == LD_FORM1);
    tok.vld  = is_form0 | is_form1;
    tok.sel  = is_form1 ? SW'(1) : SW'(0);
  end

  always_comb begin
    if (tok.vld) begin
      AST_DEC_FORM: assert (opc_bits[11:3] == 9'h0EC && opc_bits[1:0] == 2'b00); // R2
    end
  end
endmodule

// File: rtl/aux_ld_pipe.sv
module aux_ld_pipe
  import aux_pkg::*;
#(
  parameter int unsigned LAT = LD_LAT
) (
  input  logic    clk,
  input  logic    rst,
  input  ld_tok_t tok_in,
  output ld_tok_t tok_exe
);
  ld_tok_t st [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      st[0] <= '0;
    end else begin
      st[0] <= tok_in;
    end
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        st[s] <= '0;
      end else begin
        st[s] <= st[s-1];
      end
    end

    AST_PIPE_SHIFT: assert property (@(posedge clk) disable iff (rst)
      st[s].vld |-> $past(st[s-1].vld)); // R3
  end

  assign tok_exe = st[LAT-1];
endmodule

// File: rtl/aux_reg_bank.sv
module aux_reg_bank
  import aux_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ind_valid,
  input  logic [SW-1:0] ind_sel,
  input  logic          ind_inc,
  input  logic [AW-1:0] ind_step,
  input  ld_tok_t       ld_tok,
  input  logic [AW-1:0] ld_data,
  output logic [AW-1:0] rd_data,
  output logic [AW-1:0] q [NREG],
  output logic          drop_q
);
  logic [NREG-1:0] inc_hit;
  logic [NREG-1:0] ld_hit;
  logic            clash;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign inc_hit[i] = ind_valid & ind_inc & (ind_sel == SW'(i));
    assign ld_hit[i]  = ld_tok.vld & (ld_tok.sel == SW'(i));

    // D2 post-increment has priority over the EXE load
    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= '0;
      end else if (inc_hit[i]) begin
        q[i] <= q[i] + ind_step;
      end else if (ld_hit[i]) begin
        q[i] <= ld_data;
      end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (q[i] == '0)); // R1
    AST_INC_APPLY: assert property (@(posedge clk) disable iff (rst)
      inc_hit[i] |=> (q[i] == AW'($past(q[i]) + $past(ind_step)))); // R5
    AST_LOAD_COMMIT: assert property (@(posedge clk) disable iff (rst)
      (ld_hit[i] && !inc_hit[i]) |=> (q[i] == $past(ld_data))); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!ld_hit[i] && !inc_hit[i]) |=> $stable(q[i])); // R9
  end

  assign clash   = |(inc_hit & ld_hit);
  assign rd_data = q[ind_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_q <= 1'b0;
    end else begin
      drop_q <= clash;
    end
  end

  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    drop_q |-> $past(clash)); // R8
  AST_DROP_RAISE: assert property (@(posedge clk) disable iff (rst)
    clash |=> drop_q); // R6
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld_hit)); // R2
endmodule

// File: rtl/aux_addr_unit.sv
module aux_addr_unit
  import aux_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   opc_hi,
  input  logic [AW-1:0] mem_rdata,
  input  logic          ind_valid,
  input  logic          ind_sel,
  input  logic          ind_inc,
  input  logic [AW-1:0] ind_step,
  output logic [AW-1:0] addr_out,
  output logic [AW-1:0] ar0,
  output logic [AW-1:0] ar1,
  output logic          ld_drop
);
  ld_tok_t       d2_tok;
  ld_tok_t       exe_tok;
  logic [AW-1:0] regs [NREG];
  logic          unused_addr_bits;

  assign unused_addr_bits = ^opc_hi[3:0];

  aux_opc_dec u_dec (
    .opc_bits (opc_hi[15:4]),
    .tok      (d2_tok)
  );

  aux_ld_pipe #(.LAT(LD_LAT)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .tok_in  (d2_tok),
    .tok_exe (exe_tok)
  );

  aux_reg_bank u_bank (
    .clk       (clk),
    .rst       (rst),
    .ind_valid (ind_valid),
    .ind_sel   (SW'(ind_sel)),
    .ind_inc   (ind_inc),
    .ind_step  (ind_step),
    .ld_tok    (exe_tok),
    .ld_data   (mem_rdata),
    .rd_data   (addr_out),
    .q         (regs),
    .drop_q    (ld_drop)
  );

  assign ar0 = regs[0];
  assign ar1 = regs[1];

  AST_DROP_NEEDS_INC: assert property (@(posedge clk) disable iff (rst)
    ld_drop |-> $past(ind_valid && ind_inc)); // R6
endmodule

// File: tb/aux_addr_unit_test.sv
module aux_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opc_hi = 16'h0000;
  logic [15:0] mem_rdata = 16'h0000;
  logic        ind_valid = 1'b0;
  logic        ind_sel = 1'b0;
  logic        ind_inc = 1'b0;
  logic [15:0] ind_step = 16'h0000;
  logic [15:0] addr_out;
  logic [15:0] ar0;
  logic [15:0] ar1;
  logic        ld_drop;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  aux_addr_unit uut (
    .clk(clk), .rst(rst), .opc_hi(opc_hi), .mem_rdata(mem_rdata),
    .ind_valid(ind_valid), .ind_sel(ind_sel), .ind_inc(ind_inc),
    .ind_step(ind_step), .addr_out(addr_out), .ar0(ar0), .ar1(ar1),
    .ld_drop(ld_drop)
  );

  // row: opc, mrd, iv, isel, iinc, step | exp addr, ar0, ar1, drop
  localparam int NROW = 18;
  localparam logic [99:0] TBL [NROW] = '{
    {16'h7605,16'h0000,1'b1,1'b0,1'b0,16'h0000, 16'h0000,16'h0000,16'h0000,1'b0}, // R2 load r0
    {16'h0000,16'h0000,1'b1,1'b0,1'b1,16'h0005, 16'h0000,16'h0000,16'h0000,1'b0}, // R4 I1 old
    {16'h0000,16'h0000,1'b1,1'b0,1'b0,16'h0000, 16'h0005,16'h0005,16'h0000,1'b0}, // R5 I2
    {16'h0000,16'h0020,1'b1,1'b0,1'b0,16'h0000, 16'h0005,16'h0005,16'h0000,1'b0}, // R4 I3 old
    {16'h0000,16'h0000,1'b1,1'b0,1'b0,16'h0000, 16'h0020,16'h0020,16'h0000,1'b0}, // R3 I4 new
    {16'h764A,16'h0000,1'b1,1'b1,1'b0,16'h0000, 16'h0000,16'h0020,16'h0000,1'b0}, // R2 load r1
    {16'h0000,16'h0000,1'b1,1'b0,1'b1,16'hFFFF, 16'h0020,16'h0020,16'h0000,1'b0}, // R5 neg step
    {16'h0000,16'h0000,1'b0,1'b0,1'b0,16'h0000, 16'h001F,16'h001F,16'h0000,1'b0},
    {16'h0000,16'h1234,1'b1,1'b1,1'b1,16'h0002, 16'h0000,16'h001F,16'h0000,1'b0}, // R6 clash
    {16'h0000,16'h0000,1'b1,1'b1,1'b0,16'h0000, 16'h0002,16'h001F,16'h0002,1'b1}, // R6 inc won
    {16'h760F,16'h0000,1'b0,1'b0,1'b0,16'h0000, 16'h001F,16'h001F,16'h0002,1'b0}, // R8
    {16'h7610,16'h0000,1'b0,1'b0,1'b0,16'h0000, 16'h001F,16'h001F,16'h0002,1'b0}, // R2 not load
    {16'h0000,16'h0000,1'b0,1'b0,1'b0,16'h0000, 16'h001F,16'h001F,16'h0002,1'b0},
    {16'h0000,16'hBEEF,1'b1,1'b1,1'b1,16'h0003, 16'h0002,16'h001F,16'h0002,1'b0}, // R7
    {16'h0000,16'h5555,1'b0,1'b0,1'b0,16'h0000, 16'hBEEF,16'hBEEF,16'h0005,1'b0}, // R7 both
    {16'h0000,16'h0000,1'b1,1'b0,1'b0,16'h0000, 16'hBEEF,16'hBEEF,16'h0005,1'b0}, // R2 R9
    {16'h0000,16'h0000,1'b1,1'b1,1'b1,16'hFFF0, 16'h0005,16'hBEEF,16'h0005,1'b0}, // R5 wrap
    {16'h0000,16'h0000,1'b1,1'b1,1'b0,16'h0000, 16'hFFF5,16'hBEEF,16'hFFF5,1'b0}  // R5
  };

  task automatic check16(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", req, what, cyc, act, exp);
    end
  endtask

  task automatic idle();
    opc_hi = 16'h0000; mem_rdata = 16'h0000;
    ind_valid = 1'b0; ind_sel = 1'b0; ind_inc = 1'b0; ind_step = 16'h0000;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (2) @(posedge clk);
    @(negedge clk);
    // reset state, rst still high
    #5;
    check16("R1", "ar0 in reset", ar0, 16'h0000);
    check16("R1", "ar1 in reset", ar1, 16'h0000);
    check16("R1", "ld_drop in reset", {15'd0, ld_drop}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    for (int r = 0; r < NROW; r++) begin
      logic [99:0] row;
      row = TBL[r];
      opc_hi = row[99:84]; mem_rdata = row[83:68];
      ind_valid = row[67]; ind_sel = row[66]; ind_inc = row[65];
      ind_step = row[64:49];
      #5;
      if (row[67]) check16("R4", "addr_out", addr_out, row[48:33]);
      check16("R3", "ar0", ar0, row[32:17]);
      check16("R3", "ar1", ar1, row[16:1]);
      check16(row[0] ? "R6" : "R8", "ld_drop", {15'd0, ld_drop}, {15'd0, row[0]});
      @(negedge clk);
    end

    // R1: reset with a load in flight cancels it
    idle();
    opc_hi = 16'h7640;             // load r1 in D2
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mem_rdata = 16'hAAAA;          // would be EXE slot of the cancelled load
    @(negedge clk);
    mem_rdata = 16'hAAAA;
    @(negedge clk);
    idle();
    #5;
    check16("R1", "ar1 after cancelled load", ar1, 16'h0000);
    check16("R1", "ar0 after reset", ar0, 16'h0000);
    check16("R8", "ld_drop idle", {15'd0, ld_drop}, 16'h0000);

    // R3: sample cycle of mem_rdata is exactly t+3
    @(negedge clk);
    opc_hi = 16'h7603;             // t: load r0
    @(negedge clk);
    idle(); mem_rdata = 16'h1111;  // t+1
    @(negedge clk);
    mem_rdata = 16'h2222;          // t+2
    @(negedge clk);
    mem_rdata = 16'h3333;          // t+3 EXE
    #5;
    check16("R3", "ar0 still old at t+3", ar0, 16'h0000);
    @(negedge clk);
    mem_rdata = 16'h4444;          // t+4
    ind_valid = 1'b1; ind_sel = 1'b0;
    #5;
    check16("R3", "ar0 at t+4", ar0, 16'h3333);
    check16("R4", "addr_out at t+4", addr_out, 16'h3333);
    @(negedge clk);
    idle();
    #5;
    check16("R9", "ar0 after read only", ar0, 16'h3333);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule